// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block drives the two switch enables of a synchronous buck power stage. A two-bit drive request selects one of three outcomes: both switches off, the upper (high-side) switch on, or the lower (low-side) switch on. The block never turns a switch on just because a fixed time has passed. Before it enables a switch, it waits for a sense comparator to report that the opposite switch has actually turned off. It then adds a short programmable guard interval.

Three comparator outputs, already synchronous to the clock, supply that information:

- The low-side gate voltage is below its turn-on level.
- The switch node has fallen.
- The high-side gate-source voltage has collapsed.

Once the high-side gate has collapsed, a secondary timer runs. It enables the low-side switch even if the switch node never falls, so the bootstrap supply is still recharged on every cycle.

An active-low skip input holds the low-side switch off while the high side keeps following the request. This gives diode-emulation behaviour at light load. A request that changes while a wait is in progress abandons that wait and starts sequencing toward the new target.

Top module: `gate_sequencer`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `hs_en` and `ls_en` are both 0.
- R2: On a high-side request (`drive_req` = 2'b01), `ls_en` goes to 0 at the first clock edge that samples the request. `hs_en` goes to 1 exactly `P_DEAD_ON` edges after the first edge at which `lg_below` is sampled high in the waiting phase, and never earlier.
- R3: On a low-side request (`drive_req` = 2'b10), `hs_en` goes to 0 at the first edge that samples the request. `ls_en` goes to 1 exactly `P_DEAD_OFF` edges after the first edge at which `sw_below` is sampled high in the waiting phase.
- R4: During a low-side wait, the first edge that samples `hgs_below` high arms a timer. `ls_en` goes to 1 `P_TIMEOUT` edges after that edge even if `sw_below` stays low. If both paths run, the earlier one wins.
- R5: While `skip_n` is sampled 0, `ls_en` stays 0, and `hs_en` still follows high-side requests as in R2.
- R6: With a low-side request settled and `skip_n` sampled 1, `ls_en` is 1, so with `drive_req`=2'b10 the low switch is the complement of the high switch. A 0-to-1 change of `skip_n` enables it at the next edge, and a 1-to-0 change removes it at the next edge.
- R7: An off request (`drive_req` = 2'b00) drives both enables to 0 at the next edge.
- R8: `hs_en` and `ls_en` are never 1 in the same cycle, for any input sequence.
- R9: A request change that arrives during a dead-time or timeout wait abandons that wait. The abandoned switch is not enabled, and sequencing restarts toward the new request.
- R10: The unused request code 2'b11 behaves as an off request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_req | input | 2 | 00 off, 01 high side, 10 low side, 11 off |
| skip_n | input | 1 | Active-low skip: 0 holds the low side off |
| lg_below | input | 1 | Low-side gate voltage below turn-on level |
| sw_below | input | 1 | Switch node has fallen below its threshold |
| hgs_below | input | 1 | High-side gate-source voltage has collapsed |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The hardest situation to reach is the race between the switch-node path and the secondary timeout. The low-side enable must follow whichever path finishes first, and the two paths are only separated by a few cycles. The bench reaches it by arming the timeout at a fixed edge. It then sweeps the arrival edge of the switch-node sense across the whole timeout window and beyond, and checks the enable every cycle against the minimum of the two computed deadlines. Aborts are forced by changing the request while the block sits in a dead-time state, with the sense that would have completed the wait already present.

// File: rtl/gs_pkg.sv
package gs_pkg;

    typedef enum logic [1:0] {
        REQ_OFF  = 2'b00,
        REQ_HI   = 2'b01,
        REQ_LO   = 2'b10,
        REQ_RSVD = 2'b11
    } drive_req_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI_WAIT,
        ST_HI_DEAD,
        ST_HI_ON,
        ST_LO_WAIT,
        ST_LO_DEAD,
        ST_LO_ON
    } seq_state_e;

    typedef struct packed {
        logic lg_below;
        logic sw_below;
        logic hgs_below;
    } sense_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_t;

    localparam int NUM_TMR  = 3;
    localparam int TMR_DON  = 0;
    localparam int TMR_DOFF = 1;
    localparam int TMR_TO   = 2;

    function automatic int unsigned at_least(int unsigned v, int unsigned floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

    function automatic logic hi_group(seq_state_e s);
        return (s == ST_HI_WAIT) || (s == ST_HI_DEAD) || (s == ST_HI_ON);
    endfunction

    function automatic logic lo_group(seq_state_e s);
        return (s == ST_LO_WAIT) || (s == ST_LO_DEAD) || (s == ST_LO_ON);
    endfunction

endpackage

// File: rtl/gs_cycle_timer.sv
module gs_cycle_timer #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int unsigned LEN = (CYCLES < 1) ? 1 : CYCLES;
    localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Count never passes the terminal value (supports R2, R3, R4 timing)
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/gs_seq_fsm.sv
module gs_seq_fsm
    import gs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  drive_req_e           req,
    input  logic                 skip_n,
    input  sense_t               sense,
    input  logic [NUM_TMR-1:0]   tmr_done,
    output logic [NUM_TMR-1:0]   tmr_run,
    output logic [NUM_TMR-1:0]   tmr_clr,
    output gate_t                gates
);
    seq_state_e st, nxt;
    logic       to_armed;

    always_comb begin
        nxt = st;
        unique case (req)
            REQ_HI: begin
                if (!hi_group(st)) begin
                    nxt = ST_HI_WAIT;
                end else begin
                    case (st)
                        ST_HI_WAIT: if (sense.lg_below) nxt = ST_HI_DEAD;
                        ST_HI_DEAD: if (tmr_done[TMR_DON]) nxt = ST_HI_ON;
                        default:    nxt = st;
                    endcase
                end
            end
            REQ_LO: begin
                if (!lo_group(st)) begin
                    nxt = ST_LO_WAIT;
                end else begin
                    case (st)
                        ST_LO_WAIT: begin
                            if (tmr_done[TMR_TO])      nxt = ST_LO_ON;
                            else if (sense.sw_below)   nxt = ST_LO_DEAD;
                        end
                        ST_LO_DEAD: begin
                            if (tmr_done[TMR_TO] || tmr_done[TMR_DOFF]) nxt = ST_LO_ON;
                        end
                        default: nxt = st;
                    endcase
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_run[TMR_DON]  = (st == ST_HI_DEAD);
        tmr_clr[TMR_DON]  = (st != ST_HI_DEAD);
        tmr_run[TMR_DOFF] = (st == ST_LO_DEAD);
        tmr_clr[TMR_DOFF] = (st != ST_LO_DEAD);
        tmr_run[TMR_TO]   = to_armed && lo_group(st);
        tmr_clr[TMR_TO]   = !lo_group(st);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            to_armed <= 1'b0;
            gates    <= '0;
        end else begin
            st       <= nxt;
            to_armed <= lo_group(st) && (to_armed || sense.hgs_below);
            gates.hi <= (nxt == ST_HI_ON);
            gates.lo <= (nxt == ST_LO_ON) && skip_n;
        end
    end

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !(gates.hi && gates.lo));

    assert_hs_after_dead_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(gates.hi) |-> ($past(st) == ST_HI_DEAD));

    assert_ls_from_low_path_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(gates.lo) |-> lo_group($past(st)));

    assert_skip_holds_low_R5: assert property (@(posedge clk) disable iff (rst)
        gates.lo |-> $past(skip_n));

    assert_off_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (($past(req) == REQ_OFF) && !$past(rst)) |-> (!gates.hi && !gates.lo));

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
    import gs_pkg::*;
#(
    parameter int unsigned P_DEAD_ON  = 3,
    parameter int unsigned P_DEAD_OFF = 3,
    parameter int unsigned P_TIMEOUT  = 63
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] drive_req,
    input  logic       skip_n,
    input  logic       lg_below,
    input  logic       sw_below,
    input  logic       hgs_below,
    output logic       hs_en,
    output logic       ls_en
);
    localparam int unsigned DON_C  = at_least(P_DEAD_ON, 1);
    localparam int unsigned DOFF_C = at_least(P_DEAD_OFF, 1);
    localparam int unsigned TO_C   = at_least(P_TIMEOUT, DOFF_C + 1);
    localparam int unsigned LEN_TAB [NUM_TMR] = '{DON_C, DOFF_C, TO_C};

    sense_t             sense;
    gate_t              gates;
    logic [NUM_TMR-1:0] tmr_run, tmr_clr, tmr_done;

    assign sense = '{lg_below: lg_below, sw_below: sw_below, hgs_below: hgs_below};

    gs_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (drive_req_e'(drive_req)),
        .skip_n   (skip_n),
        .sense    (sense),
        .tmr_done (tmr_done),
        .tmr_run  (tmr_run),
        .tmr_clr  (tmr_clr),
        .gates    (gates)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        gs_cycle_timer #(.CYCLES(LEN_TAB[g])) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .clr  (tmr_clr[g]),
            .run  (tmr_run[g]),
            .done (tmr_done[g])
        );
    end

    assign hs_en = gates.hi;
    assign ls_en = gates.lo;

endmodule

// File: tb/test_gate_sequencer.sv
module test_gate_sequencer;
    localparam int DON  = 2;
    localparam int DOFF = 3;
    localparam int TO   = 7;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] drive_req;
    logic       skip_n, lg_below, sw_below, hgs_below;
    logic       hs_en, ls_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    gate_sequencer #(.P_DEAD_ON(DON), .P_DEAD_OFF(DOFF), .P_TIMEOUT(TO)) i_gate_sequencer (
        .clk(clk), .rst(rst), .drive_req(drive_req), .skip_n(skip_n),
        .lg_below(lg_below), .sw_below(sw_below), .hgs_below(hgs_below),
        .hs_en(hs_en), .ls_en(ls_en)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // R8: monitor on every cycle out of reset
    always @(negedge clk) begin
        if (rst === 1'b0) begin
            n_cmp++;
            if (hs_en && ls_en) begin
                n_bad++;
                $display("FAIL R8 overlap actual=11 expected=not both");
            end
        end
    end

    task automatic go_hs();
        drive_req = 2'b01; lg_below = 1; sw_below = 0; hgs_below = 0;
        tick(DON + 4);
    endtask

    task automatic go_ls();
        drive_req = 2'b10; lg_below = 1; sw_below = 1; hgs_below = 1;
        tick(DOFF + 4);
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        rst = 1; drive_req = 2'b01; skip_n = 1; lg_below = 1; sw_below = 1; hgs_below = 1;
        tick(3);
        chk(hs_en, 1'b0, "R1 reset hs");
        chk(ls_en, 1'b0, "R1 reset ls");
        rst = 0;
        tick(1);
        chk(hs_en, 1'b0, "R1 after release hs");
        chk(ls_en, 1'b0, "R1 after release ls");
        tick(DON + 3);
        chk(hs_en, 1'b1, "R2 initial hs on");

        // R2 sweep: lg_below arrives at edge j
        for (int j = 2; j <= 6; j++) begin
            go_ls();
            chk(ls_en, 1'b1, "R3 setup ls on");
            drive_req = 2'b01; lg_below = 0; sw_below = 0; hgs_below = 0;
            for (int k = 1; k <= j + DON + 1; k++) begin
                if (k == j) lg_below = 1;
                tick(1);
                chk(ls_en, 1'b0, $sformatf("R2 ls released j=%0d k=%0d", j, k));
                chk(hs_en, (k >= j + DON), $sformatf("R2 hs j=%0d k=%0d", j, k));
            end
        end

        // R3/R4 sweep: timeout armed at edge 2, sw_below arrives at edge j
        for (int j = 2; j <= TO + 3; j++) begin
            go_hs();
            drive_req = 2'b10; hgs_below = 1; sw_below = 0; lg_below = 1;
            for (int k = 1; k <= TO + 3; k++) begin
                int due;
                due = ((j + DOFF) < (2 + TO)) ? (j + DOFF) : (2 + TO);
                if (k == j) sw_below = 1;
                tick(1);
                chk(hs_en, 1'b0, $sformatf("R3 hs released j=%0d k=%0d", j, k));
                chk(ls_en, (k >= due), $sformatf("R3 R4 ls j=%0d k=%0d", j, k));
            end
        end

        // R4: late arming, switch node never falls
        go_hs();
        drive_req = 2'b10; hgs_below = 0; sw_below = 0;
        for (int k = 1; k <= 4 + TO + 1; k++) begin
            if (k == 4) hgs_below = 1;
            tick(1);
            chk(ls_en, (k >= 4 + TO), $sformatf("R4 late arm k=%0d", k));
        end

        // R5: skip holds low side off, high side still follows
        skip_n = 0;
        go_hs();
        drive_req = 2'b10; sw_below = 1; hgs_below = 1;
        for (int k = 1; k <= TO + 4; k++) begin
            tick(1);
            chk(ls_en, 1'b0, $sformatf("R5 skip ls k=%0d", k));
        end
        drive_req = 2'b01; lg_below = 1;
        tick(1 + DON);
        chk(hs_en, 1'b0, "R5 hs before dead-on");
        tick(1);
        chk(hs_en, 1'b1, "R5 hs follows request");

        // R6: skip release and reassert in the low-side state
        go_ls();
        chk(ls_en, 1'b0, "R6 skip still low");
        skip_n = 1;
        tick(1);
        chk(ls_en, 1'b1, "R6 skip released");
        chk(hs_en, 1'b0, "R6 complement hs");
        skip_n = 0;
        tick(1);
        chk(ls_en, 1'b0, "R6 skip reasserted");
        skip_n = 1;
        tick(1);

        // R7: off request
        go_hs();
        drive_req = 2'b00; tick(1);
        chk(hs_en, 1'b0, "R7 off from hs");
        chk(ls_en, 1'b0, "R7 off from hs ls");
        go_ls();
        drive_req = 2'b00; tick(1);
        chk(ls_en, 1'b0, "R7 off from ls");
        chk(hs_en, 1'b0, "R7 off from ls hs");

        // R10: reserved code behaves as off
        go_hs();
        drive_req = 2'b11;
        for (int k = 1; k <= 5; k++) begin
            tick(1);
            chk(hs_en, 1'b0, $sformatf("R10 hs k=%0d", k));
            chk(ls_en, 1'b0, $sformatf("R10 ls k=%0d", k));
        end

        // R9: abort a low-side dead-off wait toward high side
        go_hs();
        drive_req = 2'b10; hgs_below = 0; sw_below = 0;
        tick(1);
        sw_below = 1;
        tick(1);
        drive_req = 2'b01; lg_below = 0;
        for (int k = 1; k <= DOFF + TO + 2; k++) begin
            tick(1);
            chk(ls_en, 1'b0, $sformatf("R9 aborted ls k=%0d", k));
            chk(hs_en, 1'b0, $sformatf("R9 hs waits k=%0d", k));
        end
        lg_below = 1;
        tick(DON);
        chk(hs_en, 1'b0, "R9 hs before dead-on");
        tick(1);
        chk(hs_en, 1'b1, "R9 hs after restart");

        // R9: abort a high-side dead-on wait toward low side
        go_ls();
        drive_req = 2'b01; lg_below = 1;
        tick(2);
        drive_req = 2'b10; sw_below = 1; hgs_below = 0;
        for (int k = 1; k <= 2 + DOFF; k++) begin
            tick(1);
            chk(hs_en, 1'b0, $sformatf("R9 aborted hs k=%0d", k));
            chk(ls_en, (k >= 2 + DOFF), $sformatf("R9 ls restart k=%0d", k));
        end

        tick(2);
        summary();
    end
endmodule